// File: doc/BRIEF.md
# Gated Interrupt Routing Unit

This block sits between the PCI interrupt pins of the devices on three buses and a bank of 32 level-sensitive interrupt lines. The three buses are one primary bus and two secondary buses behind bridges. Each request names the bus class, the device/function number, the pin number and the level. The block turns these into a line index, stores the level for that index, and drives the line. A line is driven only while the enable of its group is set.

Eight map registers each own a group of four consecutive lines. Software can change only the enable bit (bit 31) of a map register. The low 31 bits carry a fixed identification pattern that can be read but not written. Every reset clears all enables and all stored levels, and the identification pattern is not affected. An interrupt that arrives while its group is disabled stays pending. It appears on the line as soon as the enable is set.

Top module: `irq_router`

## Requirements
- R1: For a primary bus request (`req_bus` = 0), the line index is the pin number plus 16 when bit 0 of the device/function number is 1, and the pin number plus 0 when that bit is 0.
- R2: For a secondary bus request (`req_bus` = 1), the line index is bits 4:3 of the device/function number multiplied by four, plus the pin number.
- R3: A request whose index is 32 or more changes no output line and no stored level.
- R4: When the enable of its group is set, line i follows the level of the last accepted request for index i. The change shows one clock after the request.
- R5: When the enable of its group is clear, line i is 0. A level stored while the group is disabled appears on the line one clock after a write sets the enable.
- R6: Map register k (k = 0..7) is read and written at byte address 8k+4, so address bit 2 must be 1. An address with bit 2 equal to 0 reads as zero, and writes to it are ignored. Reads are combinational.
- R7: A write to a live address changes only bit 31 (the enable) of the addressed register. The new value is visible one clock later. Bits 30:0 keep their value.
- R8: Bits 30:0 of map register k always read (0x1F << 6) | (k << 2).
- R9: While reset is asserted, all eight enables and all stored levels are cleared. When reset is released, every line is 0, and bits 30:0 of every register still read the R8 pattern.
- R10: Map register k gates exactly lines 4k to 4k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe, one cycle |
| req_bus | input | 1 | 0 = primary bus device, 1 = secondary bus device |
| req_devfn | input | 8 | Device/function number of the requester |
| req_pin | input | 5 | Interrupt pin number |
| req_level | input | 1 | Requested line level |
| reg_we | input | 1 | Map register write strobe |
| reg_addr | input | 6 | Byte address of the map register port |
| reg_wdata | input | 32 | Write data (only bit 31 is used) |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 32 | Gated interrupt lines |

## Verification
The bench builds the block with its default parameters: 32 lines in groups of four, a 5-bit pin field and a primary offset of 16. With a 5-bit pin field, indices from 0 up to 47 can occur. Random requests on both bus classes therefore reach every line and also produce indices at and above 32, which must be dropped. The 6-bit address covers both words of all eight register pairs, so random writes hit the live words and the dead words in about equal numbers.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic {
        BUS_PRIMARY   = 1'b0,
        BUS_SECONDARY = 1'b1
    } bus_sel_e;

    // Fixed identification pattern held in bits 30:0 of map register k
    function automatic logic [30:0] map_reg_seed(input int unsigned k);
        logic [31:0] v;
        v = 32'h0000_07C0 | (32'(k) << 2);
        return v[30:0];
    endfunction

endpackage

// File: rtl/irq_index_calc.sv
module irq_index_calc
    import irq_route_pkg::*;
#(
    parameter int unsigned DEVFN_W    = 8,
    parameter int unsigned PIN_W      = 5,
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned NUM_OUT    = 32,
    parameter int unsigned SEC_OFFSET = 16
) (
    input  bus_sel_e           bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [PIN_W-1:0]   pin,
    output logic [IDX_W-1:0]   idx,
    output logic               in_range
);

    always_comb begin
        unique case (bus)
            BUS_PRIMARY:
                idx = IDX_W'(pin) + (devfn[0] ? IDX_W'(SEC_OFFSET) : IDX_W'(0));
            BUS_SECONDARY:
                idx = IDX_W'({devfn[4:3], 2'b00}) + IDX_W'(pin);
            default:
                idx = '0;
        endcase
        in_range = (32'(idx) < NUM_OUT);
    end

endmodule

// File: rtl/irq_map_bank.sv
module irq_map_bank
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic [NUM_REGS-1:0] en_o
);

    localparam int unsigned REG_W = ADDR_W - 3;

    logic [NUM_REGS-1:0] en_q;
    logic [30:0]         seed [NUM_REGS];
    logic [REG_W-1:0]    sel;
    logic                live;

    assign sel  = addr[ADDR_W-1:3];
    assign live = addr[2] && (32'(sel) < NUM_REGS);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_seed
        assign seed[g] = map_reg_seed(g);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we && live) begin
            en_q[sel] <= wdata[31];
        end
    end

    always_comb begin
        rdata = '0;
        if (live) begin
            rdata = {en_q[sel], seed[sel]};
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/irq_line_gate.sv
module irq_line_gate #(
    parameter int unsigned NUM_OUT  = 32,
    parameter int unsigned GROUP    = 4,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_level,
    input  logic [IDX_W-1:0]    idx,
    input  logic                in_range,
    input  logic [NUM_REGS-1:0] en,
    output logic [NUM_OUT-1:0]  irq_out
);

    localparam int unsigned LN_W = $clog2(NUM_OUT);

    logic [NUM_OUT-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (req_valid && in_range) begin
            lvl_q[idx[LN_W-1:0]] <= req_level;
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
        assign irq_out[g] = lvl_q[g] & en[g / GROUP];
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_OUT    = 32,
    parameter int unsigned GROUP      = 4,
    parameter int unsigned PIN_W      = 5,
    parameter int unsigned DEVFN_W    = 8,
    parameter int unsigned SEC_OFFSET = 16,
    localparam int unsigned NUM_REGS  = NUM_OUT / GROUP,
    localparam int unsigned ADDR_W    = $clog2(NUM_REGS) + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [PIN_W-1:0]   req_pin,
    input  logic               req_level,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_OUT-1:0] irq_out
);

    localparam int unsigned IDX_W = $clog2(SEC_OFFSET + (2 ** PIN_W));

    logic [IDX_W-1:0]    line_idx;
    logic                line_ok;
    logic [NUM_REGS-1:0] en_vec;
    bus_sel_e            bus_sel;

    assign bus_sel = bus_sel_e'(req_bus);

    irq_index_calc #(
        .DEVFN_W   (DEVFN_W),
        .PIN_W     (PIN_W),
        .IDX_W     (IDX_W),
        .NUM_OUT   (NUM_OUT),
        .SEC_OFFSET(SEC_OFFSET)
    ) u_index (
        .bus     (bus_sel),
        .devfn   (req_devfn),
        .pin     (req_pin),
        .idx     (line_idx),
        .in_range(line_ok)
    );

    irq_map_bank #(
        .NUM_REGS(NUM_REGS),
        .ADDR_W  (ADDR_W)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .en_o (en_vec)
    );

    irq_line_gate #(
        .NUM_OUT (NUM_OUT),
        .GROUP   (GROUP),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_level(req_level),
        .idx      (line_idx),
        .in_range (line_ok),
        .en       (en_vec),
        .irq_out  (irq_out)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_OUT  = 32,
    parameter int unsigned GROUP    = 4,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned ADDR_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic [NUM_OUT-1:0]  irq_out,
    input logic [NUM_REGS-1:0] en_q
);

    localparam int unsigned REG_W = ADDR_W - 3;

    logic [NUM_OUT-1:0] allowed;
    logic [REG_W-1:0]   sel;

    assign sel = reg_addr[ADDR_W-1:3];

    always_comb begin
        for (int i = 0; i < NUM_OUT; i++) begin
            allowed[i] = en_q[i / GROUP];
        end
    end

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~allowed) == '0); // R5

    AST_DEAD_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr[2] |-> reg_rdata == 32'h0); // R6

    AST_SEED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[2] |-> reg_rdata[30:0] == map_reg_seed(32'(sel))); // R8

    AST_WRITE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[2]) |=> en_q[$past(sel)] == $past(reg_wdata[31])); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_q == '0 && irq_out == '0)); // R9

endmodule

bind irq_router irq_router_chk #(
    .NUM_OUT (NUM_OUT),
    .GROUP   (GROUP),
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_out  (irq_out),
    .en_q     (en_vec)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_bus = 1'b0;
    logic [7:0]  req_devfn = '0;
    logic [4:0]  req_pin = '0;
    logic        req_level = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_lvl;
    logic [7:0]  m_en;

    irq_router u_irq_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_pin(req_pin), .req_level(req_level),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    function automatic int calc_idx(input logic bus, input logic [7:0] devfn, input logic [4:0] pin);
        if (!bus) return int'(pin) + (devfn[0] ? 16 : 0);
        return int'((devfn & 8'h18) >> 1) + int'(pin);
    endfunction

    function automatic logic [31:0] exp_out();
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = m_lvl[i] & m_en[i / 4];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        logic [31:0] v;
        if (!a[2]) return 32'h0;
        v = 32'h7C0 | (32'(a[5:3]) << 2);
        v[31] = m_en[a[5:3]];
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply stimulus at negedge, let one posedge pass, update the model, compare.
    task automatic step();
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_lvl = '0;
            m_en = '0;
        end else begin
            if (req_valid && calc_idx(req_bus, req_devfn, req_pin) < 32)
                m_lvl[calc_idx(req_bus, req_devfn, req_pin)] = req_level;
            if (reg_we && reg_addr[2]) m_en[reg_addr[5:3]] = reg_wdata[31];
        end
        @(negedge clk);
        req_valid = 0;
        reg_we = 0;
    endtask

    task automatic send(input logic bus, input logic [7:0] devfn, input logic [4:0] pin, input logic lvl);
        req_valid = 1; req_bus = bus; req_devfn = devfn; req_pin = pin; req_level = lvl;
        step();
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 64; a += 4) begin
            reg_addr = 6'(a);
            #1;
            check(req, reg_rdata, exp_read(6'(a)));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_lvl = '0;
        m_en = '0;
        @(negedge clk);
        step();
        step();
        rst_n = 1;
        @(negedge clk);
        check("R9 reset lines", irq_out, 32'h0);
        read_all("R8 R6 reset reads");

        // R5: pending level on line 5 while disabled, released by enable (R10: reg 1)
        send(1'b0, 8'h00, 5'd5, 1'b1);
        check("R5 disabled low", irq_out, 32'h0);
        wr(6'h0C, 32'h8000_0000);
        check("R5 R10 pending released", irq_out, 32'h0000_0020);
        // R6: dead word write ignored
        wr(6'h00, 32'hFFFF_FFFF);
        reg_addr = 6'h00; #1;
        check("R6 dead word", reg_rdata, 32'h0);
        reg_addr = 6'h04; #1;
        check("R6 R7 reg0 unchanged", reg_rdata, exp_read(6'h04));
        // R7: all-ones write keeps low bits
        for (int k = 0; k < 8; k++) wr(6'((k << 3) | 4), 32'hFFFF_FFFF);
        read_all("R7 R8 all enabled");
        // R1: primary odd devfn -> 16+pin
        send(1'b0, 8'h03, 5'd2, 1'b1);
        check("R1 primary odd", irq_out, exp_out());
        check("R1 bit18", 32'(irq_out[18]), 32'd1);
        // R2: secondary devfn 0x18, pin 3 -> 15
        send(1'b1, 8'h18, 5'd3, 1'b1);
        check("R2 secondary", 32'(irq_out[15]), 32'd1);
        // R4: drop level
        send(1'b1, 8'h18, 5'd3, 1'b0);
        check("R4 follows level", 32'(irq_out[15]), 32'd0);
        // R3: index 47 and 32 ignored
        send(1'b0, 8'h01, 5'd31, 1'b1);
        check("R3 idx47 ignored", irq_out, exp_out());
        send(1'b0, 8'h01, 5'd16, 1'b1);
        check("R3 idx32 ignored", irq_out, exp_out());
        // R10: disabling reg 4 clears lines 16..19 only
        wr(6'h24, 32'h0);
        check("R10 group gate", irq_out, exp_out());

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 6) begin
                req_valid = 1; req_bus = 1'($urandom); req_devfn = 8'($urandom);
                req_pin = 5'($urandom); req_level = 1'($urandom);
            end else if (op < 9) begin
                reg_we = 1; reg_addr = 6'($urandom); reg_wdata = $urandom;
            end
            step();
            check("R1 R2 R3 R4 R5 random lines", irq_out, exp_out());
            reg_addr = 6'($urandom); #1;
            check("R6 R7 R8 random read", reg_rdata, exp_read(reg_addr));
        end

        // R9: warm reset clears enables and levels, keeps pattern
        for (int k = 0; k < 8; k++) wr(6'((k << 3) | 4), 32'h8000_0000);
        send(1'b0, 8'h00, 5'd1, 1'b1);
        rst_n = 0;
        step();
        rst_n = 1;
        @(negedge clk);
        check("R9 warm reset lines", irq_out, 32'h0);
        read_all("R9 warm reset reads");
        wr(6'h04, 32'h8000_0000);
        check("R9 level cleared", irq_out, 32'h0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule